// File: doc/BRIEF.md
# Template-Driven ACL Lookup Key Builder

This block forms the ternary-match search key for one rule entry of a packet classification table. It takes a packet's already-parsed header fields: source port mask, outer and inner VLAN tags, both MAC addresses, ethertype, TOS/protocol, L4 ports, ICMP/IGMP word, range-check hit bits and 128-bit source and destination IP addresses. It also takes an IPv6 flag, a 2-bit template choice and the owning table block's 9-bit template selector word. From these it assembles twelve 16-bit slots into six 32-bit key words.

The selector word holds three 3-bit fields, one per template choice. Each field names one of five built-in slot layouts. The chosen layout decides which header field lands in each slot. Address slots above the lowest two 16-bit groups carry data only for IPv6 traffic. An unusable selection produces an all-zero key and an error flag. The key is registered, so results appear one clock after the input strobe.

Top module: `acl_key_builder`

## Requirements
- R1: While `rst` is high at a clock edge, the next state has `key_words` all zero and `key_valid` and `key_err` low.
- R2: The layout number is `tmpl_sel[3*tid+2 : 3*tid]` for `tid` 0, 1 and 2. A `tid` of 3 is an unusable selection.
- R3: Slot i (0..11) is placed in key word 5 - i/2. Even slots go in bits 15:0 of that word and odd slots in bits 31:16. Key word w is `key_words[32*w+31 : 32*w]`.
- R4: Layout 0, slots 0 to 11: port mask low, port mask high, outer tag, source MAC parts 0,1,2, destination MAC parts 0,1,2, ethertype, inner tag, range bits.
- R5: Layout 1, slots 0 to 11: source IP groups 0,1, destination IP groups 0,1, TOS/protocol, L4 source port, L4 destination port, ICMP/IGMP, inner tag, range bits, port mask low, port mask high.
- R6: Layout 2, slots 0 to 11: destination MAC parts 0,1,2, inner tag, ethertype, TOS/protocol, L4 destination port, L4 source port, source IP groups 0,1, destination IP groups 0,1.
- R7: Layout 3 is destination IP groups 0 to 7, then L4 destination port, L4 source port, ICMP/IGMP, TOS/protocol. Layout 4 is source IP groups 0 to 7, then inner tag, range bits, port mask low, port mask high.
- R8: MAC part 0 is address bits 15:0 (byte 4 high, byte 5 low). Part 1 is bits 31:16 and part 2 is bits 47:32. Byte 0 is bits 47:40.
- R9: Port mask low/high are `port_mask[15:0]` and `[31:16]`. IP groups 0 and 1 are address bits 15:0 and 31:16 whether or not `is_v6` is set.
- R10: IP group g (2..7) carries address bits 16g+15:16g when `is_v6` is 1 and reads as zero when `is_v6` is 0.
- R11: A layout number of 5, 6 or 7, or a `tid` of 3, gives an all-zero key with `key_err` high. A usable selection gives `key_err` low.
- R12: An `in_valid` at one clock edge gives `key_valid` high after that edge for exactly one cycle, with the matching key. No `in_valid` means no `key_valid`.
- R13: While `in_valid` is low, `key_words` and `key_err` keep their last values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header fields are valid this cycle |
| tid | input | 2 | Template choice within the block |
| tmpl_sel | input | 9 | Block selector word, three 3-bit layout numbers |
| is_v6 | input | 1 | Addresses are IPv6 |
| port_mask | input | 32 | Source port mask |
| vlan_outer | input | 16 | Outer VLAN tag |
| vlan_inner | input | 16 | Inner VLAN tag |
| src_mac | input | 48 | Source MAC, byte 0 in bits 47:40 |
| dst_mac | input | 48 | Destination MAC, byte 0 in bits 47:40 |
| eth_type | input | 16 | Ethertype |
| tos_proto | input | 16 | TOS / protocol word |
| l4_src | input | 16 | L4 source port |
| l4_dst | input | 16 | L4 destination port |
| icmp_igmp | input | 16 | ICMP / IGMP word |
| range_hits | input | 16 | Range-check hit bits |
| src_ip | input | 128 | Source IP (IPv4 in bits 31:0) |
| dst_ip | input | 128 | Destination IP (IPv4 in bits 31:0) |
| key_valid | output | 1 | Key words valid (one-cycle pulse) |
| key_words | output | 192 | Six 32-bit key words, word w at 32w |
| key_err | output | 1 | Unusable template selection |

## Verification
The assertions assume `in_valid` is a clean 0/1 strobe that is sampled only on clock edges. They do not assume that the header fields are stable or meaningful when `in_valid` is low. That is why the hold property is written against the registered key and not against the inputs. The stimulus changes every header field and the selector to fresh values between strobes and during idle gaps. It drives all inputs half a period away from the active edge. It also sends back-to-back strobes, so every checked property is exercised under both continuous and sparse traffic.

// File: rtl/akb_pkg.sv
package akb_pkg;
  localparam int SLOT_W   = 16;
  localparam int N_SLOTS  = 12;
  localparam int N_WORDS  = N_SLOTS / 2;
  localparam int WORD_W   = 2 * SLOT_W;
  localparam int KEY_W    = N_WORDS * WORD_W;
  localparam int TNUM_W   = 3;
  localparam int TID_W    = 2;
  localparam int N_CHOICE = 3;
  localparam int SEL_W    = N_CHOICE * TNUM_W;
  localparam int N_FIXED  = 5;
  localparam int IP_W     = 128;
  localparam int MAC_W    = 48;
  localparam int PM_W     = 32;

  typedef enum logic [5:0] {
    F_NONE, F_PM_LO, F_PM_HI, F_VL_OUT, F_VL_IN,
    F_SA0, F_SA1, F_SA2, F_DA0, F_DA1, F_DA2,
    F_ETYPE, F_TOSPR, F_SPORT, F_DPORT, F_ICMP, F_RANGE,
    F_SRC0, F_SRC1, F_SRC2, F_SRC3, F_SRC4, F_SRC5, F_SRC6, F_SRC7,
    F_DST0, F_DST1, F_DST2, F_DST3, F_DST4, F_DST5, F_DST6, F_DST7
  } fld_e;

  typedef struct packed {
    logic [PM_W-1:0]   pmask;
    logic [15:0]       vl_out;
    logic [15:0]       vl_in;
    logic [MAC_W-1:0]  smac;
    logic [MAC_W-1:0]  dmac;
    logic [15:0]       etype;
    logic [15:0]       tospr;
    logic [15:0]       sport;
    logic [15:0]       dport;
    logic [15:0]       icmp;
    logic [15:0]       rng;
    logic [IP_W-1:0]   sip;
    logic [IP_W-1:0]   dip;
    logic              v6;
  } hdr_t;

  localparam fld_e LAY0 [N_SLOTS] = '{F_PM_LO, F_PM_HI, F_VL_OUT, F_SA0, F_SA1, F_SA2,
                                      F_DA0, F_DA1, F_DA2, F_ETYPE, F_VL_IN, F_RANGE};
  localparam fld_e LAY1 [N_SLOTS] = '{F_SRC0, F_SRC1, F_DST0, F_DST1, F_TOSPR, F_SPORT,
                                      F_DPORT, F_ICMP, F_VL_IN, F_RANGE, F_PM_LO, F_PM_HI};
  localparam fld_e LAY2 [N_SLOTS] = '{F_DA0, F_DA1, F_DA2, F_VL_IN, F_ETYPE, F_TOSPR,
                                      F_DPORT, F_SPORT, F_SRC0, F_SRC1, F_DST0, F_DST1};
  localparam fld_e LAY3 [N_SLOTS] = '{F_DST0, F_DST1, F_DST2, F_DST3, F_DST4, F_DST5,
                                      F_DST6, F_DST7, F_DPORT, F_SPORT, F_ICMP, F_TOSPR};
  localparam fld_e LAY4 [N_SLOTS] = '{F_SRC0, F_SRC1, F_SRC2, F_SRC3, F_SRC4, F_SRC5,
                                      F_SRC6, F_SRC7, F_VL_IN, F_RANGE, F_PM_LO, F_PM_HI};

  function automatic fld_e layout_field(input logic [TNUM_W-1:0] t, input int s);
    case (t)
      3'd0:    return LAY0[s];
      3'd1:    return LAY1[s];
      3'd2:    return LAY2[s];
      3'd3:    return LAY3[s];
      3'd4:    return LAY4[s];
      default: return F_NONE;
    endcase
  endfunction
endpackage

// File: rtl/akb_tmpl_pick.sv
module akb_tmpl_pick
  import akb_pkg::*;
(
  input  logic [SEL_W-1:0]  sel,
  input  logic [TID_W-1:0]  tid,
  output logic [TNUM_W-1:0] tnum,
  output logic              bad
);
  logic hit;

  always_comb begin
    tnum = '0;
    hit  = 1'b0;
    for (int c = 0; c < N_CHOICE; c++) begin
      if (tid == c[TID_W-1:0]) begin
        tnum = sel[c*TNUM_W +: TNUM_W];
        hit  = 1'b1;
      end
    end
    bad = !hit || (tnum > TNUM_W'(N_FIXED - 1));
  end
endmodule

// File: rtl/akb_slot_mux.sv
module akb_slot_mux
  import akb_pkg::*;
#(
  parameter int SLOT = 0
) (
  input  hdr_t              hdr,
  input  logic [TNUM_W-1:0] tnum,
  input  logic              bad,
  output logic [SLOT_W-1:0] val
);
  fld_e fld;

  function automatic logic [SLOT_W-1:0] ip_grp(input logic [IP_W-1:0] a, input int g,
                                                input logic v6);
    if (g < 2 || v6) return a[g*SLOT_W +: SLOT_W];
    return '0;
  endfunction

  always_comb begin
    fld = bad ? F_NONE : layout_field(tnum, SLOT);
    case (fld)
      F_PM_LO:  val = hdr.pmask[15:0];
      F_PM_HI:  val = hdr.pmask[31:16];
      F_VL_OUT: val = hdr.vl_out;
      F_VL_IN:  val = hdr.vl_in;
      F_SA0:    val = hdr.smac[15:0];
      F_SA1:    val = hdr.smac[31:16];
      F_SA2:    val = hdr.smac[47:32];
      F_DA0:    val = hdr.dmac[15:0];
      F_DA1:    val = hdr.dmac[31:16];
      F_DA2:    val = hdr.dmac[47:32];
      F_ETYPE:  val = hdr.etype;
      F_TOSPR:  val = hdr.tospr;
      F_SPORT:  val = hdr.sport;
      F_DPORT:  val = hdr.dport;
      F_ICMP:   val = hdr.icmp;
      F_RANGE:  val = hdr.rng;
      F_SRC0:   val = ip_grp(hdr.sip, 0, hdr.v6);
      F_SRC1:   val = ip_grp(hdr.sip, 1, hdr.v6);
      F_SRC2:   val = ip_grp(hdr.sip, 2, hdr.v6);
      F_SRC3:   val = ip_grp(hdr.sip, 3, hdr.v6);
      F_SRC4:   val = ip_grp(hdr.sip, 4, hdr.v6);
      F_SRC5:   val = ip_grp(hdr.sip, 5, hdr.v6);
      F_SRC6:   val = ip_grp(hdr.sip, 6, hdr.v6);
      F_SRC7:   val = ip_grp(hdr.sip, 7, hdr.v6);
      F_DST0:   val = ip_grp(hdr.dip, 0, hdr.v6);
      F_DST1:   val = ip_grp(hdr.dip, 1, hdr.v6);
      F_DST2:   val = ip_grp(hdr.dip, 2, hdr.v6);
      F_DST3:   val = ip_grp(hdr.dip, 3, hdr.v6);
      F_DST4:   val = ip_grp(hdr.dip, 4, hdr.v6);
      F_DST5:   val = ip_grp(hdr.dip, 5, hdr.v6);
      F_DST6:   val = ip_grp(hdr.dip, 6, hdr.v6);
      F_DST7:   val = ip_grp(hdr.dip, 7, hdr.v6);
      default:  val = '0;
    endcase
  end
endmodule

// File: rtl/akb_key_reg.sv
module akb_key_reg
  import akb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [KEY_W-1:0] nxt_key,
  input  logic             nxt_bad,
  output logic [KEY_W-1:0] key,
  output logic             vld,
  output logic             err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      key <= '0;
      vld <= 1'b0;
      err <= 1'b0;
    end else begin
      vld <= in_vld;
      if (in_vld) begin
        key <= nxt_bad ? '0 : nxt_key;
        err <= nxt_bad;
      end
    end
  end

  // R12
  vld_follow_chk: assert property (@(posedge clk) disable iff (rst) in_vld |=> vld);
  // R12
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !vld);
  // R13
  key_hold_chk: assert property (@(posedge clk) disable iff (rst)
                                 !in_vld |=> ($stable(key) && $stable(err)));
  // R11
  err_zero_chk: assert property (@(posedge clk) disable iff (rst) err |-> (key == '0));
endmodule

// File: rtl/acl_key_builder.sv
module acl_key_builder
  import akb_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [TID_W-1:0]    tid,
  input  logic [SEL_W-1:0]    tmpl_sel,
  input  logic                is_v6,
  input  logic [PM_W-1:0]     port_mask,
  input  logic [15:0]         vlan_outer,
  input  logic [15:0]         vlan_inner,
  input  logic [MAC_W-1:0]    src_mac,
  input  logic [MAC_W-1:0]    dst_mac,
  input  logic [15:0]         eth_type,
  input  logic [15:0]         tos_proto,
  input  logic [15:0]         l4_src,
  input  logic [15:0]         l4_dst,
  input  logic [15:0]         icmp_igmp,
  input  logic [15:0]         range_hits,
  input  logic [IP_W-1:0]     src_ip,
  input  logic [IP_W-1:0]     dst_ip,
  output logic                key_valid,
  output logic [KEY_W-1:0]    key_words,
  output logic                key_err
);
  hdr_t              hdr;
  logic [TNUM_W-1:0] tnum;
  logic              bad;
  logic [KEY_W-1:0]  nxt_key;

  always_comb begin
    hdr.pmask  = port_mask;
    hdr.vl_out = vlan_outer;
    hdr.vl_in  = vlan_inner;
    hdr.smac   = src_mac;
    hdr.dmac   = dst_mac;
    hdr.etype  = eth_type;
    hdr.tospr  = tos_proto;
    hdr.sport  = l4_src;
    hdr.dport  = l4_dst;
    hdr.icmp   = icmp_igmp;
    hdr.rng    = range_hits;
    hdr.sip    = src_ip;
    hdr.dip    = dst_ip;
    hdr.v6     = is_v6;
  end

  akb_tmpl_pick u_pick (
    .sel  (tmpl_sel),
    .tid  (tid),
    .tnum (tnum),
    .bad  (bad)
  );

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    localparam int OFF = (N_WORDS - 1 - i / 2) * WORD_W + (i % 2) * SLOT_W;
    akb_slot_mux #(.SLOT(i)) u_mux (
      .hdr  (hdr),
      .tnum (tnum),
      .bad  (bad),
      .val  (nxt_key[OFF +: SLOT_W])
    );
  end

  akb_key_reg u_reg (
    .clk     (clk),
    .rst     (rst),
    .in_vld  (in_valid),
    .nxt_key (nxt_key),
    .nxt_bad (bad),
    .key     (key_words),
    .vld     (key_valid),
    .err     (key_err)
  );
endmodule

// File: tb/sim_acl_key_builder.sv
module sim_acl_key_builder;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [1:0] tid = '0;
  logic [8:0] tmpl_sel = '0;
  logic is_v6 = 1'b0;
  logic [31:0] port_mask = '0;
  logic [15:0] vlan_outer = '0, vlan_inner = '0, eth_type = '0, tos_proto = '0;
  logic [15:0] l4_src = '0, l4_dst = '0, icmp_igmp = '0, range_hits = '0;
  logic [47:0] src_mac = '0, dst_mac = '0;
  logic [127:0] src_ip = '0, dst_ip = '0;
  logic key_valid, key_err;
  logic [191:0] key_words;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [191:0] k;
    logic         e;
    string        tag;
  } exp_t;
  exp_t sb[$];
  logic [191:0] last_k = '0;
  logic         last_e = 1'b0;

  always #2 clk = ~clk;

  acl_key_builder u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .tid(tid), .tmpl_sel(tmpl_sel),
    .is_v6(is_v6), .port_mask(port_mask), .vlan_outer(vlan_outer),
    .vlan_inner(vlan_inner), .src_mac(src_mac), .dst_mac(dst_mac),
    .eth_type(eth_type), .tos_proto(tos_proto), .l4_src(l4_src), .l4_dst(l4_dst),
    .icmp_igmp(icmp_igmp), .range_hits(range_hits), .src_ip(src_ip),
    .dst_ip(dst_ip), .key_valid(key_valid), .key_words(key_words),
    .key_err(key_err)
  );

  // Field codes: 0/1 port mask lo/hi, 2 outer, 3 inner, 4-6 src MAC parts,
  // 7-9 dst MAC parts, 10 ethertype, 11 tos, 12 sport, 13 dport, 14 icmp,
  // 15 range, 16+g source IP group g, 24+g destination IP group g.
  function automatic int lay_code(int t, int s);
    int a0[12] = '{0, 1, 2, 4, 5, 6, 7, 8, 9, 10, 3, 15};          // R4
    int a1[12] = '{16, 17, 24, 25, 11, 12, 13, 14, 3, 15, 0, 1};   // R5
    int a2[12] = '{7, 8, 9, 3, 10, 11, 13, 12, 16, 17, 24, 25};    // R6
    int a3[12] = '{24, 25, 26, 27, 28, 29, 30, 31, 13, 12, 14, 11};// R7
    int a4[12] = '{16, 17, 18, 19, 20, 21, 22, 23, 3, 15, 0, 1};   // R7
    case (t)
      0: return a0[s];
      1: return a1[s];
      2: return a2[s];
      3: return a3[s];
      default: return a4[s];
    endcase
  endfunction

  function automatic logic [15:0] code_val(int c);
    if (c >= 24) return ((c - 24) < 2 || is_v6) ? dst_ip[(c-24)*16 +: 16] : 16'h0; // R10
    if (c >= 16) return ((c - 16) < 2 || is_v6) ? src_ip[(c-16)*16 +: 16] : 16'h0; // R9
    case (c)
      0: return port_mask[15:0];
      1: return port_mask[31:16];
      2: return vlan_outer;
      3: return vlan_inner;
      4: return src_mac[15:0];   // R8
      5: return src_mac[31:16];
      6: return src_mac[47:32];
      7: return dst_mac[15:0];
      8: return dst_mac[31:16];
      9: return dst_mac[47:32];
      10: return eth_type;
      11: return tos_proto;
      12: return l4_src;
      13: return l4_dst;
      14: return icmp_igmp;
      default: return range_hits;
    endcase
  endfunction

  task automatic randomize_hdr();
    port_mask  = $urandom;
    vlan_outer = 16'($urandom);
    vlan_inner = 16'($urandom);
    src_mac    = {16'($urandom), 32'($urandom)};
    dst_mac    = {16'($urandom), 32'($urandom)};
    eth_type   = 16'($urandom);
    tos_proto  = 16'($urandom);
    l4_src     = 16'($urandom);
    l4_dst     = 16'($urandom);
    icmp_igmp  = 16'($urandom);
    range_hits = 16'($urandom);
    src_ip     = {$urandom, $urandom, $urandom, $urandom};
    dst_ip     = {$urandom, $urandom, $urandom, $urandom};
  endtask

  // Driver: drive one strobe at a falling edge and push the expected result.
  task automatic send(input logic [1:0] t_id, input logic [8:0] sel, input logic v6,
                      input string tag);
    exp_t x;
    int tn;
    @(negedge clk);
    randomize_hdr();
    tid = t_id; tmpl_sel = sel; is_v6 = v6; in_valid = 1'b1;
    tn = (t_id == 2'd3) ? 7 : int'((sel >> (3 * t_id)) & 9'h7);   // R2
    x.tag = tag;
    x.k = '0;
    x.e = (tn > 4);                                                 // R11
    if (!x.e)
      for (int s = 0; s < 12; s++)
        x.k[(5 - s / 2) * 32 + (s % 2) * 16 +: 16] = code_val(lay_code(tn, s)); // R3
    sb.push_back(x);
    last_k = x.k;
    last_e = x.e;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      randomize_hdr();
      tmpl_sel = 9'($urandom);
      tid = 2'($urandom);
      is_v6 = 1'($urandom);
    end
  endtask

  // Monitor: pop and compare whenever a result appears.
  always @(negedge clk) begin
    if (!rst && key_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R12 unexpected key_valid got 1 exp 0");
      end else begin
        exp_t x;
        x = sb.pop_front();
        if (key_words !== x.k || key_err !== x.e) begin
          errors++;
          $display("FAIL %s got key %h err %b exp key %h err %b",
                   x.tag, key_words, key_err, x.k, x.e);
        end
      end
    end
  end

  localparam logic [8:0] SEL_A = {3'd2, 3'd1, 3'd0};
  localparam logic [8:0] SEL_B = {3'd4, 3'd3, 3'd0};
  localparam logic [8:0] SEL_X = {3'd7, 3'd6, 3'd5};

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (key_words !== '0 || key_valid !== 1'b0 || key_err !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset got key %h v %b e %b exp 0 0 0", key_words, key_valid, key_err);
    end
    rst = 1'b0;
    idle(2);
    send(2'd0, SEL_A, 1'b0, "R4 R8 R9 layout0");
    send(2'd1, SEL_A, 1'b0, "R5 R9 layout1 v4");
    send(2'd2, SEL_A, 1'b1, "R6 layout2 v6");
    send(2'd1, SEL_B, 1'b1, "R7 R10 layout3 v6");
    send(2'd2, SEL_B, 1'b1, "R7 R10 layout4 v6");
    send(2'd2, SEL_B, 1'b0, "R9 R10 layout4 v4 upper zero");
    send(2'd1, SEL_B, 1'b0, "R9 R10 layout3 v4 upper zero");
    send(2'd0, SEL_B, 1'b0, "R2 choice0 of block B");
    send(2'd3, SEL_A, 1'b0, "R2 R11 tid3 unusable");
    send(2'd0, SEL_X, 1'b0, "R11 layout5");
    idle(1);
    send(2'd1, SEL_X, 1'b1, "R11 layout6");
    send(2'd2, SEL_X, 1'b0, "R11 layout7");
    idle(4);
    checks++;
    if (key_words !== last_k || key_err !== last_e || key_valid !== 1'b0) begin
      errors++;
      $display("FAIL R13 hold got key %h e %b v %b exp key %h e %b v 0",
               key_words, key_err, key_valid, last_k, last_e);
    end
    send(2'd0, SEL_A, 1'b1, "R11 error clears on good selection");
    idle(3);
    checks++;
    if (key_words !== last_k || key_err !== 1'b0) begin
      errors++;
      $display("FAIL R13 hold good key got %h e %b exp %h e 0", key_words, key_err, last_k);
    end
    for (int n = 0; n < 40; n++) begin
      send(2'($urandom), 9'($urandom), 1'($urandom), "R3 R12 mixed stream");
      if (n % 5 == 4) idle(1);
    end
    idle(3);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R12 pending results got %0d exp 0", sb.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired got running exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule